// File: doc/BRIEF.md
# Core Mode Reconfiguration Sequencer

This block carries out a change of operating mode inside one out-of-order core. The core has four modes, and each mode fixes three things together: the instruction queue, reorder buffer and load/store queue sizes, the fetch and decode width, and the clock frequency. A mode request is accepted only while the sequencer is idle. The sequencer waits until the pipeline reports that it has drained. It then walks the three banked queues to their new sizes, changing one bank at a time with a fixed settle time per bank. Next it sets the new fetch width, the decoder lane enables and the frequency-select code. Finally it waits out a fixed voltage/frequency transition and pulses `done`.

The register file, caches and branch predictor are shared by all modes, so the sequencer has no outputs that touch them. The voltage regulator and the queue storage sit outside the block. They only follow the enables and the frequency code that the block drives.

Top module: `coremorph_sequencer`

## Requirements
- R1: After reset the block is in mode 0 (average). It has 9 IQ banks, 8 ROB banks and 8 LSQ banks enabled, fetch width 4, all four decoder lanes on and `freqSel` = 16. `busy` and `done` are low.
- R2: Mode codes are 0 = average (IQ 36, ROB 128, LSQ 128, width 4, `freqSel` 16), 1 = narrow (24/64/64, width 2, 20), 2 = larger (48/256/128, width 4, 14) and 3 = smaller (12/16/16, width 1, 12). `freqSel` is in units of 100 MHz. After a switch completes, every output matches the table entry for the new mode, and `activeMode` shows the new code.
- R3: Banks hold 4 entries for the IQ and 16 entries for the ROB and LSQ. The number of enabled banks is the size divided by the bank size, rounded up. Bank i of a queue is enabled exactly when i is below that count, so the enables form a thermometer code starting at bit 0.
- R4: A bank change alters exactly one bank of one queue at a time. Successive bank changes within one switch are exactly 10 cycles apart. All IQ changes come first, then all ROB changes, then all LSQ changes.
- R5: After a request is accepted, no enable, width or frequency output changes while `pipeEmpty` is low. The first bank change happens in the cycle after `pipeEmpty` is sampled high.
- R6: Fetch width, decoder lanes and `freqSel` change together, 10 cycles after the last bank change and only once every queue has reached its new size. Decoder lane i is on exactly when i is below the fetch width.
- R7: `done` rises exactly 200 cycles after the cycle in which `freqSel` changes.
- R8: A request for the mode that is already active raises `done` in the next cycle. `busy` is not raised and no other output changes.
- R9: A request presented while `busy` is high, or while `done` is high, is ignored.
- R10: `busy` is high from the cycle after a request for a different mode is accepted, through the last cycle before `done`. It is low in the cycle where `done` is high.
- R11: `done` is a single-cycle pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Synchronous active-low reset |
| reqValid | input | 1 | Mode change request strobe |
| reqMode | input | 2 | Requested mode code |
| pipeEmpty | input | 1 | Pipeline has fully drained |
| iqBankEn | output | 12 | Instruction queue bank power enables |
| robBankEn | output | 16 | Reorder buffer bank power enables |
| lsqBankEn | output | 8 | Load/store queue bank power enables |
| decEn | output | 4 | Decoder lane enables |
| fetchWidth | output | 3 | Instructions fetched per cycle |
| freqSel | output | 5 | Clock target in 100 MHz units |
| activeMode | output | 2 | Mode currently in force |
| busy | output | 1 | Switch in progress |
| done | output | 1 | Switch (or same-mode acknowledge) complete |

## Verification
The hardest case to reach is a request that arrives while a long switch is still running. It must leave the table target unchanged even though it names a different mode, and it has to land while the bank walk is under way. The stimulus first holds `pipeEmpty` low for several cycles after a request, which exercises the drain hold. It then fires a conflicting request in the middle of the bank walk. After `done`, the bench checks that `activeMode` and every enable match the first request. A cycle-accurate behavioural model is compared on every clock. Monitors also measure the 10-cycle bank spacing and the 200-cycle frequency wait.

// File: rtl/coremorph_pkg.sv
package coremorph_pkg;

  typedef enum logic [1:0] {
    MODE_AVG     = 2'd0,
    MODE_NARROW  = 2'd1,
    MODE_LARGE   = 2'd2,
    MODE_SMALL   = 2'd3
  } coreMode_t;

  typedef struct packed {
    logic load;        // capture requested mode as target
    logic stepBank;    // move one bank toward target
    logic applyFront;  // set width, decoders and frequency
    logic commit;      // target becomes active mode
  } seqStrobe_t;

  typedef struct packed {
    logic [8:0] iqEntries;
    logic [8:0] robEntries;
    logic [8:0] lsqEntries;
    logic [2:0] width;
    logic [4:0] freq;   // 100 MHz units
  } modeCfg_t;

  function automatic modeCfg_t modeCfg(input logic [1:0] m);
    modeCfg_t c;
    case (m)
      2'd0:    c = '{9'd36, 9'd128, 9'd128, 3'd4, 5'd16};
      2'd1:    c = '{9'd24, 9'd64,  9'd64,  3'd2, 5'd20};
      2'd2:    c = '{9'd48, 9'd256, 9'd128, 3'd4, 5'd14};
      default: c = '{9'd12, 9'd16,  9'd16,  3'd1, 5'd12};
    endcase
    return c;
  endfunction

  function automatic int bankCount(input int entries, input int bankSize);
    return (entries + bankSize - 1) / bankSize;
  endfunction

endpackage

// File: rtl/coremorph_datapath.sv
module coremorph_datapath
  import coremorph_pkg::*;
#(
  parameter int IQ_BANK   = 4,
  parameter int ROB_BANK  = 16,
  parameter int LSQ_BANK  = 16,
  parameter int IQ_BANKS  = 12,
  parameter int ROB_BANKS = 16,
  parameter int LSQ_BANKS = 8,
  parameter int LANES     = 4
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  seqStrobe_t           strobe,
  input  logic [1:0]           reqMode,
  output logic                 sameMode,
  output logic                 banksMatch,
  output logic [IQ_BANKS-1:0]  iqBankEn,
  output logic [ROB_BANKS-1:0] robBankEn,
  output logic [LSQ_BANKS-1:0] lsqBankEn,
  output logic [LANES-1:0]     decEn,
  output logic [2:0]           fetchWidth,
  output logic [4:0]           freqSel,
  output logic [1:0]           activeMode
);
  localparam int MAX_BANKS = (IQ_BANKS > ROB_BANKS) ?
                             ((IQ_BANKS > LSQ_BANKS) ? IQ_BANKS : LSQ_BANKS) :
                             ((ROB_BANKS > LSQ_BANKS) ? ROB_BANKS : LSQ_BANKS);
  localparam int CNT_W = $clog2(MAX_BANKS + 1);
  localparam modeCfg_t RST_CFG = modeCfg(2'd0);
  localparam int RST_IQ  = bankCount(int'(RST_CFG.iqEntries), IQ_BANK);
  localparam int RST_ROB = bankCount(int'(RST_CFG.robEntries), ROB_BANK);
  localparam int RST_LSQ = bankCount(int'(RST_CFG.lsqEntries), LSQ_BANK);

  logic [1:0]       curMode, tgtMode;
  logic [CNT_W-1:0] iqCnt, robCnt, lsqCnt;
  logic [CNT_W-1:0] iqTgt, robTgt, lsqTgt;
  modeCfg_t         tgtCfg;

  always_comb begin
    tgtCfg = modeCfg(tgtMode);
    iqTgt  = CNT_W'(bankCount(int'(tgtCfg.iqEntries), IQ_BANK));
    robTgt = CNT_W'(bankCount(int'(tgtCfg.robEntries), ROB_BANK));
    lsqTgt = CNT_W'(bankCount(int'(tgtCfg.lsqEntries), LSQ_BANK));
  end

  assign sameMode   = (reqMode == curMode);
  assign banksMatch = (iqCnt == iqTgt) && (robCnt == robTgt) && (lsqCnt == lsqTgt);
  assign activeMode = curMode;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      curMode    <= 2'd0;
      tgtMode    <= 2'd0;
      iqCnt      <= CNT_W'(RST_IQ);
      robCnt     <= CNT_W'(RST_ROB);
      lsqCnt     <= CNT_W'(RST_LSQ);
      fetchWidth <= RST_CFG.width;
      freqSel    <= RST_CFG.freq;
    end else begin
      if (strobe.load) tgtMode <= reqMode;
      if (strobe.stepBank) begin
        if (iqCnt != iqTgt)
          iqCnt <= (iqCnt < iqTgt) ? iqCnt + 1'b1 : iqCnt - 1'b1;
        else if (robCnt != robTgt)
          robCnt <= (robCnt < robTgt) ? robCnt + 1'b1 : robCnt - 1'b1;
        else if (lsqCnt != lsqTgt)
          lsqCnt <= (lsqCnt < lsqTgt) ? lsqCnt + 1'b1 : lsqCnt - 1'b1;
      end
      if (strobe.applyFront) begin
        fetchWidth <= tgtCfg.width;
        freqSel    <= tgtCfg.freq;
      end
      if (strobe.commit) curMode <= tgtMode;
    end
  end

  for (genvar i = 0; i < IQ_BANKS; i++) begin : g_iq
    assign iqBankEn[i] = (iqCnt > CNT_W'(i));
  end
  for (genvar i = 0; i < ROB_BANKS; i++) begin : g_rob
    assign robBankEn[i] = (robCnt > CNT_W'(i));
  end
  for (genvar i = 0; i < LSQ_BANKS; i++) begin : g_lsq
    assign lsqBankEn[i] = (lsqCnt > CNT_W'(i));
  end
  for (genvar i = 0; i < LANES; i++) begin : g_dec
    assign decEn[i] = (fetchWidth > 3'(i));
  end

  AST_ONE_BANK_STEP: assert property (@(posedge clk) disable iff (!rstN)
    $countones({iqCnt != $past(iqCnt), robCnt != $past(robCnt), lsqCnt != $past(lsqCnt)}) <= 1); // R4

  AST_FRONT_AFTER_BANKS: assert property (@(posedge clk) disable iff (!rstN)
    (freqSel != $past(freqSel)) |-> banksMatch); // R6

endmodule

// File: rtl/coremorph_control.sv
module coremorph_control
  import coremorph_pkg::*;
#(
  parameter int BANK_CYCLES = 10,
  parameter int DVFS_CYCLES = 200
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       reqValid,
  input  logic       pipeEmpty,
  input  logic       sameMode,
  input  logic       banksMatch,
  output seqStrobe_t strobe,
  output logic       busy,
  output logic       done
);
  localparam int WAIT_MAX = (BANK_CYCLES > DVFS_CYCLES) ? BANK_CYCLES : DVFS_CYCLES;
  localparam int WAIT_W   = $clog2(WAIT_MAX + 1);

  typedef enum logic [1:0] {S_IDLE, S_DRAIN, S_BANKS, S_DVFS} seqState_t;

  seqState_t   state, stateNext;
  logic [WAIT_W-1:0] waitCnt, waitNext;
  logic        doneNext;

  always_comb begin
    stateNext = state;
    waitNext  = waitCnt;
    doneNext  = 1'b0;
    strobe    = '0;
    case (state)
      S_IDLE: if (reqValid && !done) begin
        if (sameMode) doneNext = 1'b1;
        else begin
          strobe.load = 1'b1;
          stateNext   = S_DRAIN;
        end
      end
      S_DRAIN: if (pipeEmpty) begin
        stateNext = S_BANKS;
        waitNext  = '0;
      end
      S_BANKS: begin
        if (waitCnt != '0) waitNext = waitCnt - 1'b1;
        else if (!banksMatch) begin
          strobe.stepBank = 1'b1;
          waitNext        = WAIT_W'(BANK_CYCLES - 1);
        end else begin
          strobe.applyFront = 1'b1;
          waitNext          = WAIT_W'(DVFS_CYCLES - 1);
          stateNext         = S_DVFS;
        end
      end
      default: begin
        if (waitCnt != '0) waitNext = waitCnt - 1'b1;
        else begin
          strobe.commit = 1'b1;
          doneNext      = 1'b1;
          stateNext     = S_IDLE;
        end
      end
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state   <= S_IDLE;
      waitCnt <= '0;
      done    <= 1'b0;
    end else begin
      state   <= stateNext;
      waitCnt <= waitNext;
      done    <= doneNext;
    end
  end

  assign busy = (state != S_IDLE);

  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done); // R11

  AST_DONE_NOT_BUSY: assert property (@(posedge clk) disable iff (!rstN)
    done |-> !busy); // R10

  AST_DRAIN_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    (state == S_DRAIN && !pipeEmpty) |=> (state == S_DRAIN)); // R5

endmodule

// File: rtl/coremorph_sequencer.sv
module coremorph_sequencer
  import coremorph_pkg::*;
#(
  parameter int IQ_BANK     = 4,
  parameter int ROB_BANK    = 16,
  parameter int LSQ_BANK    = 16,
  parameter int IQ_BANKS    = 12,
  parameter int ROB_BANKS   = 16,
  parameter int LSQ_BANKS   = 8,
  parameter int LANES       = 4,
  parameter int BANK_CYCLES = 10,
  parameter int DVFS_CYCLES = 200
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 reqValid,
  input  logic [1:0]           reqMode,
  input  logic                 pipeEmpty,
  output logic [IQ_BANKS-1:0]  iqBankEn,
  output logic [ROB_BANKS-1:0] robBankEn,
  output logic [LSQ_BANKS-1:0] lsqBankEn,
  output logic [LANES-1:0]     decEn,
  output logic [2:0]           fetchWidth,
  output logic [4:0]           freqSel,
  output logic [1:0]           activeMode,
  output logic                 busy,
  output logic                 done
);
  seqStrobe_t strobe;
  logic       sameMode, banksMatch;

  coremorph_control #(
    .BANK_CYCLES(BANK_CYCLES), .DVFS_CYCLES(DVFS_CYCLES)
  ) u_ctrl (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .pipeEmpty(pipeEmpty),
    .sameMode(sameMode), .banksMatch(banksMatch), .strobe(strobe),
    .busy(busy), .done(done)
  );

  coremorph_datapath #(
    .IQ_BANK(IQ_BANK), .ROB_BANK(ROB_BANK), .LSQ_BANK(LSQ_BANK),
    .IQ_BANKS(IQ_BANKS), .ROB_BANKS(ROB_BANKS), .LSQ_BANKS(LSQ_BANKS),
    .LANES(LANES)
  ) u_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .reqMode(reqMode),
    .sameMode(sameMode), .banksMatch(banksMatch),
    .iqBankEn(iqBankEn), .robBankEn(robBankEn), .lsqBankEn(lsqBankEn),
    .decEn(decEn), .fetchWidth(fetchWidth), .freqSel(freqSel),
    .activeMode(activeMode)
  );

endmodule

// File: tb/sim_coremorph_sequencer.sv
`timescale 1ns/1ps
module sim_coremorph_sequencer;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        reqValid = 1'b0;
  logic [1:0]  reqMode = 2'd0;
  logic        pipeEmpty = 1'b0;
  logic [11:0] iqBankEn;
  logic [15:0] robBankEn;
  logic [7:0]  lsqBankEn;
  logic [3:0]  decEn;
  logic [2:0]  fetchWidth;
  logic [4:0]  freqSel;
  logic [1:0]  activeMode;
  logic        busy, done;

  int checks = 0;
  int errors = 0;
  int cycle = 0;

  always #2 clk = ~clk;

  coremorph_sequencer u0 (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqMode(reqMode),
    .pipeEmpty(pipeEmpty), .iqBankEn(iqBankEn), .robBankEn(robBankEn),
    .lsqBankEn(lsqBankEn), .decEn(decEn), .fetchWidth(fetchWidth),
    .freqSel(freqSel), .activeMode(activeMode), .busy(busy), .done(done)
  );

  // mode table, written from the requirements
  function automatic int tIq(int m);
    case (m) 0: return 9; 1: return 6; 2: return 12; default: return 3; endcase
  endfunction
  function automatic int tRob(int m);
    case (m) 0: return 8; 1: return 4; 2: return 16; default: return 1; endcase
  endfunction
  function automatic int tLsq(int m);
    case (m) 0: return 8; 1: return 4; 2: return 8; default: return 1; endcase
  endfunction
  function automatic int tWid(int m);
    case (m) 0: return 4; 1: return 2; 2: return 4; default: return 1; endcase
  endfunction
  function automatic int tFrq(int m);
    case (m) 0: return 16; 1: return 20; 2: return 14; default: return 12; endcase
  endfunction
  function automatic int thermo(int n);
    return (1 << n) - 1;
  endfunction

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d (cycle %0d)", tag, act, exp, cycle);
    end
  endtask

  // ---------------- behavioural reference model ----------------
  int mPhase, mCnt, mIq, mRob, mLsq, mWid, mFrq, mMode, mTgt;
  bit mDone;

  always @(posedge clk) begin
    bit nd;
    nd = 1'b0;
    if (!rstN) begin
      mPhase = 0; mCnt = 0; mIq = 9; mRob = 8; mLsq = 8;
      mWid = 4; mFrq = 16; mMode = 0; mTgt = 0;
    end else begin
      if (mPhase == 0) begin
        if (reqValid && !mDone) begin
          if (int'(reqMode) == mMode) nd = 1'b1;
          else begin mTgt = int'(reqMode); mPhase = 1; end
        end
      end else if (mPhase == 1) begin
        if (pipeEmpty) begin mPhase = 2; mCnt = 0; end
      end else if (mPhase == 2) begin
        if (mCnt != 0) mCnt--;
        else if (mIq != tIq(mTgt)) begin mIq += (mIq < tIq(mTgt)) ? 1 : -1; mCnt = 9; end
        else if (mRob != tRob(mTgt)) begin mRob += (mRob < tRob(mTgt)) ? 1 : -1; mCnt = 9; end
        else if (mLsq != tLsq(mTgt)) begin mLsq += (mLsq < tLsq(mTgt)) ? 1 : -1; mCnt = 9; end
        else begin mWid = tWid(mTgt); mFrq = tFrq(mTgt); mCnt = 199; mPhase = 3; end
      end else begin
        if (mCnt != 0) mCnt--;
        else begin mMode = mTgt; mPhase = 0; nd = 1'b1; end
      end
    end
    mDone = nd;
  end

  // per-cycle comparison, away from the active edge
  int lastBankChg = -1;
  int freqChg = -1;
  int prevIq, prevRob, prevLsq, prevFrq;
  bit monOn = 0;

  always @(negedge clk) begin
    cycle++;
    if (rstN) begin
      check(int'(iqBankEn)  == thermo(mIq),  "R3 iq enables",  int'(iqBankEn),  thermo(mIq));
      check(int'(robBankEn) == thermo(mRob), "R3 rob enables", int'(robBankEn), thermo(mRob));
      check(int'(lsqBankEn) == thermo(mLsq), "R3 lsq enables", int'(lsqBankEn), thermo(mLsq));
      check(int'(fetchWidth) == mWid, "R6 fetch width", int'(fetchWidth), mWid);
      check(int'(decEn) == thermo(mWid), "R6 decoder lanes", int'(decEn), thermo(mWid));
      check(int'(freqSel) == mFrq, "R2 freq code", int'(freqSel), mFrq);
      check(int'(activeMode) == mMode, "R2 active mode", int'(activeMode), mMode);
      check(busy == (mPhase != 0), "R10 busy", int'(busy), int'(mPhase != 0));
      check(done == mDone, "R11 done", int'(done), int'(mDone));
      if (monOn) begin
        int nchg;
        nchg = (int'(iqBankEn) != prevIq) + (int'(robBankEn) != prevRob) + (int'(lsqBankEn) != prevLsq);
        if (nchg != 0) begin
          check(nchg == 1, "R4 single queue per step", nchg, 1);
          if (lastBankChg >= 0) check(cycle - lastBankChg == 10, "R4 bank spacing", cycle - lastBankChg, 10);
          lastBankChg = cycle;
        end
        if (int'(freqSel) != prevFrq) begin
          if (lastBankChg >= 0) check(cycle - lastBankChg == 10, "R6 front after banks", cycle - lastBankChg, 10);
          freqChg = cycle;
        end
        if (done) begin
          if (freqChg >= 0) check(cycle - freqChg == 200, "R7 dvfs wait", cycle - freqChg, 200);
          lastBankChg = -1; freqChg = -1;
        end
      end
      prevIq = int'(iqBankEn); prevRob = int'(robBankEn);
      prevLsq = int'(lsqBankEn); prevFrq = int'(freqSel);
      monOn = 1;
    end
  end

  // watchdog
  initial begin
    repeat (100000) @(negedge clk);
    errors++;
    $display("FAIL R10 watchdog expired actual=hung expected=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  task automatic request(input int m);
    @(negedge clk);
    reqValid = 1'b1; reqMode = 2'(m);
    @(negedge clk);
    reqValid = 1'b0;
  endtask

  task automatic waitDone();
    while (!done) @(negedge clk);
  endtask

  task automatic checkMode(input int m, input string tag);
    check(int'(activeMode) == m, tag, int'(activeMode), m);
    check(int'(iqBankEn) == thermo(tIq(m)), "R2 iq size", int'(iqBankEn), thermo(tIq(m)));
    check(int'(robBankEn) == thermo(tRob(m)), "R2 rob size", int'(robBankEn), thermo(tRob(m)));
    check(int'(lsqBankEn) == thermo(tLsq(m)), "R2 lsq size", int'(lsqBankEn), thermo(tLsq(m)));
    check(int'(fetchWidth) == tWid(m), "R2 width", int'(fetchWidth), tWid(m));
    check(int'(freqSel) == tFrq(m), "R2 freq", int'(freqSel), tFrq(m));
  endtask

  initial begin
    int snapIq;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R1 reset state
    checkMode(0, "R1 reset mode");
    check(busy == 0 && done == 0, "R1 flags idle", int'({busy, done}), 0);
    check(decEn == 4'hF, "R1 decoders", int'(decEn), 15);

    // switch to smaller with a slow drain (R5) and an interfering request (R9)
    pipeEmpty = 1'b0;
    request(3);
    snapIq = int'(iqBankEn);
    repeat (6) @(negedge clk);
    check(busy == 1, "R10 busy during drain", int'(busy), 1);
    check(int'(iqBankEn) == snapIq && freqSel == 5'd16, "R5 frozen in drain", int'(iqBankEn), snapIq);
    pipeEmpty = 1'b1;
    repeat (40) @(negedge clk);
    reqValid = 1'b1; reqMode = 2'd1;      // R9 ignored while busy
    @(negedge clk);
    reqValid = 1'b0;
    waitDone();
    check(done == 1 && busy == 0, "R10 busy low at done", int'(busy), 0);
    reqValid = 1'b1; reqMode = 2'd0;      // R9 ignored while done is high
    @(negedge clk);
    reqValid = 1'b0;
    check(done == 0, "R11 done one cycle", int'(done), 0);
    check(busy == 0, "R9 request during done ignored", int'(busy), 0);
    checkMode(3, "R9 first target kept");
    check(decEn == 4'h1, "R6 one lane", int'(decEn), 1);

    // same-mode request (R8)
    request(3);
    check(done == 1 && busy == 0, "R8 same-mode ack", int'({busy, done}), 1);
    @(negedge clk);
    check(done == 0, "R8 ack pulse ends", int'(done), 0);
    checkMode(3, "R8 nothing changed");

    // further switches with the pipeline already empty
    request(2); waitDone(); @(negedge clk); checkMode(2, "R2 larger");
    request(1); waitDone(); @(negedge clk); checkMode(1, "R2 narrow");
    check(decEn == 4'h3, "R6 two lanes", int'(decEn), 3);
    request(0); waitDone(); @(negedge clk); checkMode(0, "R2 average");
    request(2); waitDone(); @(negedge clk); checkMode(2, "R2 average to larger");

    repeat (3) @(negedge clk);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule